// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block moves a small processor core between three power states: Run, Stop and Suspend. The core asks for a sleep state by writing one of two request bits. The sequencer holds that request until the core reports, with a retire strobe, that the instruction has finished. Only then does it close the clock enables for the CPU, the high-frequency oscillator and the digital peripherals. In Suspend, a separate enable keeps the port-match logic clocked. The external oscillator enable stays at the value it had in Run.

Stop is the deeper state. It ends only through a reset. That reset can come from the reset input or from a built-in missing-clock detector. The detector counts ticks of an always-on low-frequency clock and clears each time it sees a system-clock pulse. Suspend ends on a port match or on a comparator-low event, the latter only when that source is enabled. In that case the core continues at the next instruction: the block gives a one-cycle resume pulse, plus a wake-interrupt pulse when the interrupt is enabled. A reset during Suspend also ends it. The block then raises a reset request, which sends the core back to the reset vector at address 0x0000.

Top module: `lpm_sequencer`

## Requirements
- R1: After the synchronous reset `rst`, `mode_state` is 2'b00 (Run). `cpu_clk_en`, `hfosc_en`, `periph_clk_en` and `pm_clk_en` are 1. `resume_next`, `wake_irq`, `reset_req` and `xosc_en` are 0.
- R2: In a cycle where `instr_retire` is 1 and a Stop request is pending or written, the state becomes Stop (2'b01) at the next clock edge. From that edge on, all four clock enables are 0.
- R3: A Suspend request that retires puts the state in Suspend (2'b10). In Suspend, `cpu_clk_en`, `hfosc_en` and `periph_clk_en` are 0 and `pm_clk_en` stays 1.
- R4: When both request bits are pending or written at the retire, the block enters Stop.
- R5: In Stop, `port_match` and `cmp_low` have no effect. An `ext_rst` pulse or a missing-clock timeout returns the state to Run on the next edge, with a one-cycle `reset_req` and no `resume_next`.
- R6: In Suspend, a `port_match` returns the state to Run on the next edge. `resume_next` is then 1 for exactly one cycle.
- R7: In Suspend, `cmp_low` wakes the block only while `cmp_wake_en` is 1. Otherwise the block stays in Suspend.
- R8: `wake_irq` pulses together with `resume_next` when `wake_irq_en` is 1, and stays 0 when it is 0.
- R9: When a reset event and a wake event fall in the same Suspend cycle, the reset wins: `reset_req` is 1 and `resume_next` is 0.
- R10: While `mcd_en` is 1, the detector counts `lf_tick` cycles that have no `sysclk_act`. A `sysclk_act` clears the count. The MCD_LIMIT-th counted tick is a reset event. While `mcd_en` is 0, no timeout occurs.
- R11: In Run, `port_match` and `cmp_low` produce no `resume_next` and no state change.
- R12: `xosc_en` follows `xosc_cfg` one cycle later while the state is Run. It holds its value while the state is Stop or Suspend.
- R13: A request bit written without `instr_retire` leaves the state in Run until a later retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on sequencer clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| stop_wr | input | 1 | Core writes the Stop request bit |
| susp_wr | input | 1 | Core writes the Suspend request bit |
| instr_retire | input | 1 | The current instruction has completed |
| ext_rst | input | 1 | External reset event |
| port_match | input | 1 | Port-match wake event |
| cmp_low | input | 1 | Comparator output is low |
| cmp_wake_en | input | 1 | Allows comparator-low to wake from Suspend |
| wake_irq_en | input | 1 | Raises a wake interrupt on a Suspend wake |
| mcd_en | input | 1 | Missing-clock detector enable |
| lf_tick | input | 1 | Always-on low-frequency tick |
| sysclk_act | input | 1 | A system-clock edge was observed |
| xosc_cfg | input | 1 | Requested external oscillator enable |
| mode_state | output | 2 | 00 Run, 01 Stop, 10 Suspend |
| cpu_clk_en | output | 1 | CPU clock enable |
| hfosc_en | output | 1 | High-frequency internal oscillator enable |
| periph_clk_en | output | 1 | Digital peripheral clock enable |
| pm_clk_en | output | 1 | Port-match logic clock enable |
| xosc_en | output | 1 | External oscillator enable |
| resume_next | output | 1 | One-cycle pulse: continue at the next instruction |
| wake_irq | output | 1 | One-cycle wake interrupt pulse |
| reset_req | output | 1 | One-cycle pulse: restart at the reset vector |

## Verification
The two functions that can fall in the same clock cycle are the wake path in Suspend and the reset path. The reset path is driven by an `ext_rst` pulse or by a missing-clock timeout. The bench asserts `port_match` and `ext_rst` in the same Suspend cycle. It expects a reset request and no resume pulse. It also lets the detector time out while Stop ignores wake events. A behavioural model, updated on every edge, predicts each output. Named checks then sample the cycle right after each decisive edge.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        PM_RUN  = 2'b00,
        PM_STOP = 2'b01,
        PM_SUSP = 2'b10
    } pm_state_e;

    // Index of each request bit; a lower index wins when both are set.
    localparam int unsigned REQ_STOP = 0;
    localparam int unsigned REQ_SUSP = 1;
    localparam int unsigned REQ_N    = 2;

    typedef struct packed {
        logic cpu;
        logic hfosc;
        logic periph;
        logic pmatch;
    } gate_t;

    typedef struct packed {
        logic resume;
        logic irq;
    } wake_t;

    function automatic gate_t gates_for(pm_state_e st);
        gate_t g;
        g.cpu    = (st == PM_RUN);
        g.hfosc  = (st == PM_RUN);
        g.periph = (st == PM_RUN);
        g.pmatch = (st != PM_STOP);
        return g;
    endfunction

    function automatic pm_state_e target_for(logic [REQ_N-1:0] sel);
        pm_state_e t;
        t = PM_RUN;
        if (sel[REQ_STOP])      t = PM_STOP;
        else if (sel[REQ_SUSP]) t = PM_SUSP;
        return t;
    endfunction

endpackage

// File: rtl/lpm_req_latch.sv
module lpm_req_latch
    import lpm_pkg::*;
#(
    parameter int unsigned N = REQ_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         flush,
    input  logic         arm,
    input  logic [N-1:0] wr,
    input  logic         retire,
    output logic         enter,
    output logic [N-1:0] sel
);

    logic [N-1:0] pend_q;
    logic [N-1:0] req;

    assign req   = pend_q | (wr & {N{arm}});
    assign enter = arm & retire & (|req);

    // Lowest set index wins.
    always_comb begin
        sel = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) sel = N'(1) << i;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_pend
        always_ff @(posedge clk) begin
            if (rst || flush || enter)
                pend_q[g] <= 1'b0;
            else if (arm)
                pend_q[g] <= pend_q[g] | wr[g];
        end
    end

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        enter |-> ($countones(sel) == 1)); // R4

    AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (rst)
        enter |=> (pend_q == '0)); // R13

endmodule

// File: rtl/lpm_mcd.sv
module lpm_mcd #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic en,
    input  logic lf_tick,
    input  logic sysclk_act,
    output logic hit
);

    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign hit = en && !sysclk_act && lf_tick && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (rst || clr || !en || sysclk_act || hit)
            cnt_q <= '0;
        else if (lf_tick)
            cnt_q <= cnt_q + 1'b1;
    end

    AST_MCD_CLEAR_ON_ACT: assert property (@(posedge clk) disable iff (rst)
        sysclk_act |=> (cnt_q == '0)); // R10

    AST_MCD_BOUND: assert property (@(posedge clk) disable iff (rst)
        (cnt_q < CW'(LIMIT))); // R10

    AST_MCD_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |-> !hit); // R10

endmodule

// File: rtl/lpm_wake_sort.sv
module lpm_wake_sort
    import lpm_pkg::*;
(
    input  pm_state_e state,
    input  logic      rst_evt,
    input  logic      port_match,
    input  logic      cmp_low,
    input  logic      cmp_wake_en,
    input  logic      wake_irq_en,
    output wake_t     cause
);

    logic src_any;

    always_comb begin
        src_any      = port_match | (cmp_low & cmp_wake_en);
        cause.resume = (state == PM_SUSP) & src_any & ~rst_evt;
        cause.irq    = cause.resume & wake_irq_en;
    end

endmodule

// File: rtl/lpm_sequencer.sv
module lpm_sequencer
    import lpm_pkg::*;
#(
    parameter int unsigned MCD_LIMIT = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       stop_wr,
    input  logic       susp_wr,
    input  logic       instr_retire,
    input  logic       ext_rst,
    input  logic       port_match,
    input  logic       cmp_low,
    input  logic       cmp_wake_en,
    input  logic       wake_irq_en,
    input  logic       mcd_en,
    input  logic       lf_tick,
    input  logic       sysclk_act,
    input  logic       xosc_cfg,
    output logic [1:0] mode_state,
    output logic       cpu_clk_en,
    output logic       hfosc_en,
    output logic       periph_clk_en,
    output logic       pm_clk_en,
    output logic       xosc_en,
    output logic       resume_next,
    output logic       wake_irq,
    output logic       reset_req
);

    pm_state_e         state_q;
    logic              mcd_hit;
    logic              rst_evt;
    logic              enter;
    logic [REQ_N-1:0]  wr_vec;
    logic [REQ_N-1:0]  sel;
    wake_t             cause;
    gate_t             gates;
    logic              resume_q, irq_q, rreq_q, xosc_q;

    assign rst_evt = ext_rst | mcd_hit;

    always_comb begin
        wr_vec           = '0;
        wr_vec[REQ_STOP] = stop_wr;
        wr_vec[REQ_SUSP] = susp_wr;
    end

    lpm_req_latch #(.N(REQ_N)) u_req (
        .clk    (clk),
        .rst    (rst),
        .flush  (rst_evt),
        .arm    (state_q == PM_RUN),
        .wr     (wr_vec),
        .retire (instr_retire),
        .enter  (enter),
        .sel    (sel)
    );

    lpm_mcd #(.LIMIT(MCD_LIMIT)) u_mcd (
        .clk        (clk),
        .rst        (rst),
        .clr        (ext_rst),
        .en         (mcd_en),
        .lf_tick    (lf_tick),
        .sysclk_act (sysclk_act),
        .hit        (mcd_hit)
    );

    lpm_wake_sort u_wake (
        .state       (state_q),
        .rst_evt     (rst_evt),
        .port_match  (port_match),
        .cmp_low     (cmp_low),
        .cmp_wake_en (cmp_wake_en),
        .wake_irq_en (wake_irq_en),
        .cause       (cause)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= PM_RUN;
            resume_q <= 1'b0;
            irq_q    <= 1'b0;
            rreq_q   <= 1'b0;
        end else begin
            resume_q <= 1'b0;
            irq_q    <= 1'b0;
            rreq_q   <= 1'b0;
            if (rst_evt) begin
                state_q <= PM_RUN;
                rreq_q  <= 1'b1;
            end else begin
                case (state_q)
                    PM_RUN:  if (enter) state_q <= target_for(sel);
                    PM_SUSP: if (cause.resume) begin
                        state_q  <= PM_RUN;
                        resume_q <= 1'b1;
                        irq_q    <= cause.irq;
                    end
                    PM_STOP: state_q <= PM_STOP;
                    default: state_q <= PM_RUN;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            xosc_q <= 1'b0;
        else if (state_q == PM_RUN)
            xosc_q <= xosc_cfg;
    end

    assign gates         = gates_for(state_q);
    assign mode_state    = state_q;
    assign cpu_clk_en    = gates.cpu;
    assign hfosc_en      = gates.hfosc;
    assign periph_clk_en = gates.periph;
    assign pm_clk_en     = gates.pmatch;
    assign xosc_en       = xosc_q;
    assign resume_next   = resume_q;
    assign wake_irq      = irq_q;
    assign reset_req     = rreq_q;

    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_STOP && !rst_evt) |=> (state_q == PM_STOP)); // R5

    AST_ENTRY_ON_RETIRE: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_RUN && !instr_retire) |=> (state_q == PM_RUN)); // R13

    AST_RESUME_ORIGIN: assert property (@(posedge clk) disable iff (rst)
        resume_q |-> ($past(state_q) == PM_SUSP && state_q == PM_RUN)); // R6

    AST_RESUME_PULSE: assert property (@(posedge clk) disable iff (rst)
        resume_q |=> !resume_q); // R6

    AST_RESET_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        rreq_q |-> (!resume_q && state_q == PM_RUN)); // R9

    AST_IRQ_WITH_RESUME: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> resume_q); // R8

    AST_RUN_NO_WAKE: assert property (@(posedge clk) disable iff (rst)
        (state_q == PM_RUN) |=> !resume_q); // R11

    AST_XOSC_HELD: assert property (@(posedge clk) disable iff (rst)
        (state_q != PM_RUN) |=> $stable(xosc_q)); // R12

endmodule

// File: tb/lpm_sequencer_tb.sv
module lpm_sequencer_tb_top;

    localparam int LIM = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stop_wr = 0, susp_wr = 0, instr_retire = 0, ext_rst = 0;
    logic port_match = 0, cmp_low = 0, cmp_wake_en = 0, wake_irq_en = 0;
    logic mcd_en = 0, lf_tick = 0, sysclk_act = 0, xosc_cfg = 0;
    logic [1:0] mode_state;
    logic cpu_clk_en, hfosc_en, periph_clk_en, pm_clk_en, xosc_en;
    logic resume_next, wake_irq, reset_req;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lpm_sequencer #(.MCD_LIMIT(LIM)) dut_i (
        .clk(clk), .rst(rst), .stop_wr(stop_wr), .susp_wr(susp_wr),
        .instr_retire(instr_retire), .ext_rst(ext_rst), .port_match(port_match),
        .cmp_low(cmp_low), .cmp_wake_en(cmp_wake_en), .wake_irq_en(wake_irq_en),
        .mcd_en(mcd_en), .lf_tick(lf_tick), .sysclk_act(sysclk_act),
        .xosc_cfg(xosc_cfg), .mode_state(mode_state), .cpu_clk_en(cpu_clk_en),
        .hfosc_en(hfosc_en), .periph_clk_en(periph_clk_en), .pm_clk_en(pm_clk_en),
        .xosc_en(xosc_en), .resume_next(resume_next), .wake_irq(wake_irq),
        .reset_req(reset_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on every rising edge.
    int m_state = 0, m_cnt = 0;
    bit m_ps = 0, m_pu = 0, m_res = 0, m_irq = 0, m_rr = 0, m_x = 0;

    always @(posedge clk) begin
        bit hit, evt, wake, sreq, ureq;
        hit = mcd_en && !sysclk_act && lf_tick && (m_cnt == LIM - 1);
        if (rst) begin
            m_state = 0; m_cnt = 0; m_ps = 0; m_pu = 0;
            m_res = 0; m_irq = 0; m_rr = 0; m_x = 0;
        end else begin
            evt  = ext_rst || hit;
            wake = (m_state == 2) && (port_match || (cmp_low && cmp_wake_en));
            m_res = 0; m_irq = 0; m_rr = 0;
            if (m_state == 0) m_x = xosc_cfg;
            if (evt) begin
                m_state = 0; m_ps = 0; m_pu = 0; m_rr = 1;
            end else if (m_state == 0) begin
                sreq = m_ps || stop_wr;
                ureq = m_pu || susp_wr;
                if (instr_retire && (sreq || ureq)) begin
                    m_state = sreq ? 1 : 2; m_ps = 0; m_pu = 0;
                end else begin
                    m_ps = sreq; m_pu = ureq;
                end
            end else if (m_state == 2 && wake) begin
                m_state = 0; m_res = 1; m_irq = wake_irq_en;
            end
            if (ext_rst || !mcd_en || sysclk_act || hit) m_cnt = 0;
            else if (lf_tick) m_cnt = m_cnt + 1;
        end
        #5;
        chk("R2 mode_state", mode_state, m_state);
        chk("R3 cpu_clk_en", cpu_clk_en, m_state == 0);
        chk("R3 hfosc_en", hfosc_en, m_state == 0);
        chk("R3 periph_clk_en", periph_clk_en, m_state == 0);
        chk("R3 pm_clk_en", pm_clk_en, m_state != 1);
        chk("R12 xosc_en", xosc_en, m_x);
        chk("R6 resume_next", resume_next, m_res);
        chk("R8 wake_irq", wake_irq, m_irq);
        chk("R5 reset_req", reset_req, m_rr);
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic settle();
        @(posedge clk); #5;
    endtask

    task automatic do_ext_reset();
        @(negedge clk); ext_rst = 1;
        settle();
        chk("R5 reset_req on ext_rst", reset_req, 1);
        chk("R5 back to run", mode_state, 0);
        chk("R5 no resume on reset", resume_next, 0);
        @(negedge clk); ext_rst = 0;
    endtask

    task automatic enter_susp();
        @(negedge clk); susp_wr = 1; instr_retire = 1;
        settle();
        chk("R3 enters suspend", mode_state, 2);
        @(negedge clk); susp_wr = 0; instr_retire = 0;
    endtask

    initial begin
        step(3);
        rst = 0;
        settle();
        chk("R1 reset mode", mode_state, 0);
        chk("R1 cpu enable", cpu_clk_en, 1);
        chk("R1 pm enable", pm_clk_en, 1);
        chk("R1 reset_req low", reset_req, 0);
        chk("R1 xosc low", xosc_en, 0);

        // R13: write without retire stays in Run.
        @(negedge clk); stop_wr = 1;
        @(negedge clk); stop_wr = 0;
        step(2);
        chk("R13 no entry before retire", mode_state, 0);
        xosc_cfg = 1;
        instr_retire = 1;
        settle();
        chk("R2 stop after retire", mode_state, 1);
        chk("R2 hfosc off", hfosc_en, 0);
        chk("R2 pm off in stop", pm_clk_en, 0);
        chk("R12 xosc captured", xosc_en, 1);
        @(negedge clk); instr_retire = 0; xosc_cfg = 0;

        // R5: wake sources ignored in Stop.
        cmp_wake_en = 1; port_match = 1; cmp_low = 1;
        step(3);
        chk("R5 stop ignores wake", mode_state, 1);
        chk("R12 xosc held in stop", xosc_en, 1);
        port_match = 0; cmp_low = 0;
        do_ext_reset();

        // R3, R12, R6: Suspend and port-match wake, no interrupt.
        xosc_cfg = 1;
        step(2);
        enter_susp();
        chk("R3 pm kept in suspend", pm_clk_en, 1);
        chk("R3 cpu off in suspend", cpu_clk_en, 0);
        xosc_cfg = 0;
        step(2);
        chk("R12 xosc held in suspend", xosc_en, 1);
        port_match = 1;
        settle();
        chk("R6 resume pulse", resume_next, 1);
        chk("R8 no irq when disabled", wake_irq, 0);
        chk("R6 back to run", mode_state, 0);
        @(negedge clk); port_match = 0;
        settle();
        chk("R6 pulse one cycle", resume_next, 0);

        // R7 and R8: comparator gating and wake interrupt.
        enter_susp();
        cmp_wake_en = 0; cmp_low = 1;
        step(3);
        chk("R7 cmp masked", mode_state, 2);
        cmp_wake_en = 1; wake_irq_en = 1;
        settle();
        chk("R7 cmp wakes", resume_next, 1);
        chk("R8 wake irq", wake_irq, 1);
        @(negedge clk); cmp_low = 0; wake_irq_en = 0;

        // R11: wake events in Run ignored.
        port_match = 1;
        step(3);
        chk("R11 no resume in run", resume_next, 0);
        chk("R11 stays run", mode_state, 0);
        port_match = 0;

        // R9: reset and wake in the same Suspend cycle.
        enter_susp();
        port_match = 1; ext_rst = 1;
        settle();
        chk("R9 reset wins", reset_req, 1);
        chk("R9 no resume", resume_next, 0);
        @(negedge clk); port_match = 0; ext_rst = 0;

        // R4 and R10: both bits, then missing-clock timeout.
        mcd_en = 1; sysclk_act = 1;
        step(2);
        stop_wr = 1; susp_wr = 1; instr_retire = 1;
        settle();
        chk("R4 stop has priority", mode_state, 1);
        @(negedge clk); stop_wr = 0; susp_wr = 0; instr_retire = 0; sysclk_act = 0;
        for (int k = 0; k < LIM - 1; k++) begin
            lf_tick = 1; @(negedge clk); lf_tick = 0; @(negedge clk);
        end
        chk("R10 no timeout before limit", mode_state, 1);
        lf_tick = 1;
        settle();
        chk("R10 timeout reset", reset_req, 1);
        chk("R10 timeout leaves stop", mode_state, 0);
        @(negedge clk); lf_tick = 0; sysclk_act = 1;

        // R10: detector disabled never fires.
        mcd_en = 0;
        @(negedge clk); stop_wr = 1; instr_retire = 1;
        @(negedge clk); stop_wr = 0; instr_retire = 0; sysclk_act = 0;
        for (int k = 0; k < 3 * LIM; k++) begin
            lf_tick = 1; @(negedge clk); lf_tick = 0; @(negedge clk);
        end
        chk("R10 disabled detector silent", mode_state, 1);
        do_ext_reset();
        step(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule